// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog timer with a 16-bit up-counter. The counter advances once per prescaled tick, and the division ratio comes from a small select field. When the counter rolls past its all-ones value, the block raises a request for one cycle, which a system reset controller can use. It also sets a flag that stays set, so software can later learn that the watchdog expired. To keep the watchdog from expiring, software reloads the counter with 65536 minus the number of ticks it wants before expiry.

Software reaches the block through a single-cycle 32-bit register port with three registers: the count, a control/status register and a spare control byte. A write is accepted only when its upper bits carry a key, and each register class has its own key. Any other write is dropped without a trace. After each accepted write, a busy flag stays up for a fixed number of cycles, which models the delay of crossing into the counting domain. Software must wait for the busy flag to clear before it turns the timer on.

Top module: `keyed_wdog`

## Requirements
- R1: After reset, the count, control/status and spare registers all read zero, and `rst_req` is low.
- R2: A write to offset 0x0 loads bits 15:0 into the count only when bits 31:16 equal 0x5A5A. The count reads back in bits 15:0, with bits 31:16 at zero. A write with any other key changes nothing.
- R3: Writes to offsets 0x4 (control/status) and 0x8 (spare) take bits 7:0 only when bits 31:8 equal 0xA5A5A5. With any other key they change nothing.
- R4: Control/status bits 2:0 select the tick divider. The encodings 0 through 7 give 1, 4, 16, 32, 64, 128, 1024 and 4096. While the timer is enabled, the count rises by one every divider cycles, so a value v loaded at a clock edge rolls over exactly divider*(65536-v) cycles later.
- R5: Control/status bit 7 enables counting. While it is 0, the count does not change except through a keyed load.
- R6: Control/status bit 4 sets when the count wraps from 0xFFFF to 0x0000. It then stays set until an accepted control/status write with bit 4 equal to 0. Writing 1 to bit 4, or a write that is rejected, leaves it set.
- R7: Control/status bit 5 reads 1 for exactly BUSY_CYC cycles (default 3) after each accepted write, then reads 0. A rejected write does not raise it.
- R8: A control/status write with bit 7 set that arrives while bit 5 is 1 is discarded completely. The timer stays disabled.
- R9: A keyed count write while the timer is enabled acts as a refresh. It loads the new value at once and restarts the divider phase, so the next increment comes a full divider period later.
- R10: `rst_req` is high for exactly one cycle, on the cycle where the wrap occurs. On that same cycle bit 4 first reads 1.
- R11: Reads of any offset other than 0x0, 0x4 and 0x8 return zero. Writes to such offsets change no state and do not raise bit 5.
- R12: The spare register at 0x8 holds bits 7:0 of its last accepted write and reads them back in bits 7:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all state |
| rst_n | input | 1 | Asynchronous active-low reset |
| we | input | 1 | Write strobe, one write per cycle |
| addr | input | ADDR_W | Byte offset of the register |
| wdata | input | 32 | Write data including the key |
| rdata | output | 32 | Read data for `addr`, combinational |
| rst_req | output | 1 | One-cycle reset request on rollover |

## Verification
The expiry time is swept across all eight divider encodings from the same three-tick reload. The cycle count from the reload to the request is compared with divider*3, which separates each ratio from its neighbours and detects any skew of one cycle in the phase. A second refresh, issued partway through a count, shows whether the phase is restarted or kept. Writes are tried with wrong keys, at unmapped offsets, and with an enable bit set while the busy flag is up. Each case is checked against the expected register contents and the expected busy timing.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
   localparam int REG_W    = 32;
   localparam int CNT_W    = 16;
   localparam int CTL_W    = 8;
   localparam int CKS_W    = 3;
   localparam int N_DIV    = 1 << CKS_W;
   localparam int MAX_LOG2 = 12;

   localparam logic [REG_W-1:CNT_W] CNT_KEY = 16'h5A5A;
   localparam logic [REG_W-1:CTL_W] CTL_KEY = 24'hA5A5A5;

   localparam int OFS_COUNT = 0;
   localparam int OFS_CTRL  = 4;
   localparam int OFS_SPARE = 8;

   localparam int EN_BIT   = 7;
   localparam int BUSY_BIT = 5;
   localparam int OVF_BIT  = 4;

   typedef enum logic [1:0] {
      SEL_NONE,
      SEL_COUNT,
      SEL_CTRL,
      SEL_SPARE
   } reg_sel_e;

   function automatic int div_log2(input int idx);
      case (idx)
         0:       return 0;
         1:       return 2;
         2:       return 4;
         3:       return 5;
         4:       return 6;
         5:       return 7;
         6:       return 10;
         default: return MAX_LOG2;
      endcase
   endfunction
endpackage

// File: rtl/wdog_decode.sv
module wdog_decode
   import wdog_pkg::*;
#(
   parameter int ADDR_W = 4
) (
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [REG_W-1:0]  wdata,
   output reg_sel_e          sel,
   output logic              count_wr,
   output logic              ctrl_wr,
   output logic              spare_wr
);
   logic count_key_ok;
   logic ctl_key_ok;

   assign count_key_ok = (wdata[REG_W-1:CNT_W] == CNT_KEY);
   assign ctl_key_ok   = (wdata[REG_W-1:CTL_W] == CTL_KEY);

   always_comb begin
      if (addr == ADDR_W'(OFS_COUNT))
         sel = SEL_COUNT;
      else if (addr == ADDR_W'(OFS_CTRL))
         sel = SEL_CTRL;
      else if (addr == ADDR_W'(OFS_SPARE))
         sel = SEL_SPARE;
      else
         sel = SEL_NONE;
   end

   assign count_wr = we && (sel == SEL_COUNT) && count_key_ok;
   assign ctrl_wr  = we && (sel == SEL_CTRL)  && ctl_key_ok;
   assign spare_wr = we && (sel == SEL_SPARE) && ctl_key_ok;
endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler
   import wdog_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             restart,
   input  logic [CKS_W-1:0] cks,
   output logic             tick
);
   localparam int PH_W = (MAX_LOG2 > 0) ? MAX_LOG2 : 1;

   logic [PH_W-1:0] limit [N_DIV];
   logic [PH_W-1:0] phase_q;

   for (genvar i = 0; i < N_DIV; i++) begin : g_limit
      assign limit[i] = PH_W'((1 << div_log2(i)) - 1);
   end

   assign tick = run && (phase_q >= limit[cks]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         phase_q <= '0;
      else if (restart || !run || tick)
         phase_q <= '0;
      else
         phase_q <= phase_q + 1'b1;
   end

   // R9: restart always returns the phase to zero
   a_r9_phase_restart: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (phase_q == '0));
endmodule

// File: rtl/wdog_busy.sv
module wdog_busy #(
   parameter int HOLD = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   initial assert (HOLD >= 1) else $error("wdog_busy: HOLD must be at least 1");

   if (HOLD == 1) begin : g_single
      logic flag_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) flag_q <= 1'b0;
         else        flag_q <= start;
      end
      assign busy = flag_q;
   end else begin : g_count
      localparam int BW = $clog2(HOLD + 1);
      logic [BW-1:0] left_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            left_q <= '0;
         else if (start)
            left_q <= BW'(HOLD);
         else if (left_q != '0)
            left_q <= left_q - 1'b1;
      end
      assign busy = (left_q != '0);
   end
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
   import wdog_pkg::*;
#(
   parameter int ADDR_W   = 4,
   parameter int BUSY_CYC = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [REG_W-1:0]  wdata,
   output logic [REG_W-1:0]  rdata,
   output logic              rst_req
);
   initial assert (ADDR_W >= 4) else $error("keyed_wdog: ADDR_W too small for the map");

   reg_sel_e         sel;
   logic             count_wr, ctrl_wr, spare_wr;
   logic             ctrl_acc, any_acc;
   logic             busy, tick, wrap;

   logic [CNT_W-1:0] count_q;
   logic [CKS_W-1:0] cks_q;
   logic             en_q;
   logic             ovf_q;
   logic [CTL_W-1:0] spare_q;
   logic             req_q;

   wdog_decode #(.ADDR_W(ADDR_W)) u_dec (
      .we       (we),
      .addr     (addr),
      .wdata    (wdata),
      .sel      (sel),
      .count_wr (count_wr),
      .ctrl_wr  (ctrl_wr),
      .spare_wr (spare_wr)
   );

   // an enabling write while the crossing is still pending is dropped
   assign ctrl_acc = ctrl_wr && !(busy && wdata[EN_BIT]);
   assign any_acc  = count_wr || ctrl_acc || spare_wr;

   wdog_busy #(.HOLD(BUSY_CYC)) u_busy (
      .clk   (clk),
      .rst_n (rst_n),
      .start (any_acc),
      .busy  (busy)
   );

   wdog_prescaler u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (en_q),
      .restart (count_wr),
      .cks     (cks_q),
      .tick    (tick)
   );

   assign wrap = tick && !count_wr && (count_q == '1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count_q <= '0;
      else if (count_wr)
         count_q <= wdata[CNT_W-1:0];
      else if (tick)
         count_q <= count_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cks_q <= '0;
         en_q  <= 1'b0;
      end else if (ctrl_acc) begin
         cks_q <= wdata[CKS_W-1:0];
         en_q  <= wdata[EN_BIT];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ovf_q <= 1'b0;
      else if (wrap)
         ovf_q <= 1'b1;
      else if (ctrl_acc && !wdata[OVF_BIT])
         ovf_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         spare_q <= '0;
      else if (spare_wr)
         spare_q <= wdata[CTL_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_q <= 1'b0;
      else        req_q <= wrap;
   end

   assign rst_req = req_q;

   always_comb begin
      rdata = '0;
      case (sel)
         SEL_COUNT: rdata[CNT_W-1:0] = count_q;
         SEL_CTRL: begin
            rdata[EN_BIT]    = en_q;
            rdata[BUSY_BIT]  = busy;
            rdata[OVF_BIT]   = ovf_q;
            rdata[CKS_W-1:0] = cks_q;
         end
         SEL_SPARE: rdata[CTL_W-1:0] = spare_q;
         default:   rdata = '0;
      endcase
   end

   // R10: the request never lasts longer than one cycle
   a_r10_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> !rst_req);

   // R10: a request is always accompanied by the sticky flag
   a_r10_req_flag: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> ovf_q);

   // R6: the flag only drops through an accepted clearing write
   a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_q && !(ctrl_acc && !wdata[OVF_BIT])) |=> ovf_q);

   // R5: a disabled timer holds its count
   a_r5_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q && !count_wr) |=> $stable(count_q));

   // R7: every accepted write raises the busy flag
   a_r7_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
      any_acc |=> busy);

   // R8: no enabling while busy
   a_r8_no_enable: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !en_q && ctrl_wr && wdata[EN_BIT]) |=> !en_q);

   // R2: a wrong key at the count offset leaves a stopped count alone
   a_r2_key_guard: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr == ADDR_W'(OFS_COUNT) && wdata[REG_W-1:CNT_W] != CNT_KEY && !en_q)
      |=> $stable(count_q));
endmodule

// File: tb/sim_keyed_wdog.sv
`timescale 1ns/1ps
module sim_keyed_wdog;
   localparam logic [3:0] A_CNT   = 4'h0;
   localparam logic [3:0] A_CTRL  = 4'h4;
   localparam logic [3:0] A_SPARE = 4'h8;
   localparam logic [3:0] A_HOLE  = 4'hC;
   localparam int         HOLD    = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        we = 1'b0;
   logic [3:0]  addr = 4'h0;
   logic [31:0] wdata = 32'h0;
   logic [31:0] rdata;
   logic        rst_req;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   keyed_wdog #(.ADDR_W(4), .BUSY_CYC(HOLD)) u0 (
      .clk(clk), .rst_n(rst_n), .we(we), .addr(addr),
      .wdata(wdata), .rdata(rdata), .rst_req(rst_req)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      we = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      we = 1'b0; wdata = 32'h0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      addr = a;
      #1;
      d = rdata;
   endtask

   task automatic wait_idle();
      logic [31:0] v;
      for (int i = 0; i < 50; i++) begin
         rd(A_CTRL, v);
         if (!v[5]) return;
         @(negedge clk);
      end
   endtask

   function automatic int ratio(input int k);
      case (k)
         0: return 1;    1: return 4;    2: return 16;   3: return 32;
         4: return 64;   5: return 128;  6: return 1024; default: return 4096;
      endcase
   endfunction

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
   end

   initial begin
      logic [31:0] v, s_cnt, s_spare;
      int n, lim;

      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(A_CNT, v);   chk("R1 count", v, 32'h0);
      rd(A_CTRL, v);  chk("R1 ctrl", v, 32'h0);
      rd(A_SPARE, v); chk("R1 spare", v, 32'h0);
      chk("R1 rst_req", {31'h0, rst_req}, 32'h0);

      // R2 wrong key then right key
      wr(A_CNT, 32'h5A5B_1111);
      rd(A_CNT, v);  chk("R2 bad key count", v, 32'h0);
      rd(A_CTRL, v); chk("R7 no busy on rejected write", v, 32'h0);
      wr(A_CNT, 32'h5A5A_1234);
      rd(A_CNT, v);  chk("R2 keyed load", v, 32'h0000_1234);
      rd(A_CTRL, v); chk("R7 busy after write", v, 32'h20);
      @(negedge clk); @(negedge clk);
      rd(A_CTRL, v); chk("R7 busy last cycle", v, 32'h20);
      @(negedge clk);
      rd(A_CTRL, v); chk("R7 busy cleared", v, 32'h0);

      // R3 / R12 control keys
      wr(A_SPARE, 32'hA5A5A4_3C);
      rd(A_SPARE, v); chk("R3 spare bad key", v, 32'h0);
      wr(A_SPARE, 32'hA5A5A5_3C);
      rd(A_SPARE, v); chk("R12 spare readback", v, 32'h3C);
      wr(A_CTRL, 32'h00A5A5_87);
      rd(A_CTRL, v); chk("R3 ctrl bad key", v & 32'hFFFF_FFDF, 32'h0);
      wait_idle();

      // R5 frozen while disabled
      repeat (20) @(negedge clk);
      rd(A_CNT, v); chk("R5 frozen count", v, 32'h1234);

      // R8 enabling while busy is dropped
      wr(A_CNT, 32'h5A5A_1000);
      wr(A_CTRL, 32'hA5A5A5_80);
      rd(A_CTRL, v); chk("R8 enable dropped", v & 32'h80, 32'h0);
      rd(A_CNT, v);  chk("R8 count still", v, 32'h1000);
      wait_idle();

      // R4 divide by one, linear count
      wr(A_CTRL, 32'hA5A5A5_80);
      rd(A_CNT, v); chk("R4 start value", v, 32'h1000);
      repeat (10) @(negedge clk);
      rd(A_CNT, v); chk("R4 ratio 1 rate", v, 32'h100A);

      // R4 / R6 / R10 sweep over all divider encodings
      for (int k = 0; k < 8; k++) begin
         wait_idle();
         wr(A_CTRL, 32'hA5A5A5_00 | k);
         wait_idle();
         wr(A_CTRL, 32'hA5A5A5_80 | k);
         wr(A_CNT, 32'h5A5A_FFFD);
         n = 0;
         lim = ratio(k) * 3 + 100;
         while (!rst_req && n < lim) begin
            @(negedge clk);
            n++;
         end
         chk($sformatf("R4 expiry cycles cks=%0d", k), n, ratio(k) * 3);
         rd(A_CNT, v);  chk("R6 wrapped to zero", v, 32'h0);
         rd(A_CTRL, v); chk("R10 flag with request", v & 32'h10, 32'h10);
         @(negedge clk);
         chk("R10 single cycle", {31'h0, rst_req}, 32'h0);
      end

      // R6 flag clearing rules
      wait_idle();
      wr(A_CTRL, 32'hA5A5A5_17);
      rd(A_CTRL, v); chk("R6 write one keeps flag", v & 32'h10, 32'h10);
      wr(A_CTRL, 32'hA5A5A4_07);
      rd(A_CTRL, v); chk("R6 bad key keeps flag", v & 32'h10, 32'h10);
      wait_idle();
      wr(A_CTRL, 32'hA5A5A5_07);
      rd(A_CTRL, v); chk("R6 cleared", v & 32'hDF, 32'h07);

      // R9 refresh postpones expiry and restarts phase (ratio 16)
      wait_idle();
      wr(A_CTRL, 32'hA5A5A5_82);
      wr(A_CNT, 32'h5A5A_FFFD);
      repeat (40) @(negedge clk);
      chk("R9 no early request", {31'h0, rst_req}, 32'h0);
      wr(A_CNT, 32'h5A5A_FFFD);
      rd(A_CNT, v); chk("R9 immediate reload", v, 32'hFFFD);
      n = 0;
      while (!rst_req && n < 200) begin
         @(negedge clk);
         n++;
      end
      chk("R9 expiry after refresh", n, 48);

      // R11 unmapped offsets
      wait_idle();
      wr(A_CTRL, 32'hA5A5A5_00);
      wait_idle();
      rd(A_CNT, s_cnt);
      rd(A_SPARE, s_spare);
      wr(A_HOLE, 32'h5A5A_0001);
      wr(4'h1, 32'hA5A5A5_FF);
      rd(A_HOLE, v);  chk("R11 hole reads zero", v, 32'h0);
      rd(A_CTRL, v);  chk("R11 no busy no change", v, 32'h0);
      rd(A_CNT, v);   chk("R11 count kept", v, s_cnt);
      rd(A_SPARE, v); chk("R11 spare kept", v, s_spare);

      summary();
   end
endmodule